// File: doc/BRIEF.md
# Ethernet Transmit Stop and Pause Arbiter

This block decides, cycle by cycle, what the transmit side of a simple Ethernet MAC may start next. It grants data frames to the frame engine. It halts those grants gracefully when software asks for a stop. It injects a single MAC Control PAUSE frame when software requests flow control. It also holds data frames back for the time that a received PAUSE frame demands. Serialisation, CRC, the transmit FIFO and the PHY side belong to other blocks.

Software drives a small register-style write port with three fields: a stop bit, a pause-request bit that sets only and clears itself, and a full-duplex bit. The frame engine reports when a frame is queued, when it finishes and when it ends early in a collision. The receive path supplies a strobe with a pause quanta value. A prescaler provides one tick per 512 bit times. The block answers with one-cycle grant pulses, a stop-complete interrupt pulse plus a sticky copy of it, status bits, and the four address bytes that go into the PAUSE frame's source field.

Top module: `eth_tx_arbiter`

## Requirements
- R1: Under synchronous active-high reset, every grant, interrupt, event and status output is 0, and the arbiter is idle.
- R2: When idle with no stop, no pause request, no received-pause hold, a queued frame and a free medium, `grant_data` pulses for one cycle, one clock after the inputs are seen. No further grant follows until `frm_done` or `frm_col`, and `grant_data` and `grant_pause` are never high together.
- R3: When the stop bit is set during a frame, that frame runs to its end. `stop_irq` then pulses one clock after the arbiter returns to idle, and no data frame is granted while the bit stays set.
- R4: When the stop bit is set while idle, `stop_irq` pulses once, one clock after `st_stop` rises. It pulses again only after the bit has been cleared and set once more.
- R5: Clearing the stop bit lets a queued frame be granted one clock after `st_stop` falls.
- R6: A collision (`frm_col`) while stopped returns the arbiter to idle and it holds. The same still-queued frame is granted again after the stop bit is cleared.
- R7: A write with the pause-request field at 1 sets `st_xoff`. After the current frame ends, `grant_pause` and `stop_irq` pulse together. When that PAUSE frame reports `frm_done`, `st_xoff` clears in the same clock and data grants resume on the next one.
- R8: A requested PAUSE frame is still granted while data frames are held by the stop bit or by a received-pause hold. In that case `stop_irq` does not pulse a second time if the stop has already been acknowledged.
- R9: `rx_pause_vld` with a non-zero quanta Q sets `st_rx_pause` on the next clock and blocks data grants. The bit clears on the clock of the Q-th `quanta_tick`. A new reception reloads the count, and a quanta of 0 clears the hold at once.
- R10: `pause_sa_lo` equals the value of `mac_addr_lo` one clock earlier, which gives bytes 0 to 3 of the PAUSE source address.
- R11: With `st_fdx` at 1, frames start regardless of `crs` and `col_in`. With it at 0, a frame starts only when both are 0.
- R12: A write to the full-duplex field takes effect only while `mac_en` is 0. While `mac_en` is 1, it leaves `st_fdx` unchanged.
- R13: Each `stop_irq` pulse sets `stop_evt`. `stop_evt` stays set until `evt_clr` is 1, and a new pulse takes priority over a clear in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_en | input | 1 | MAC enabled; locks the duplex field while high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_stop | input | 1 | Stop bit value written |
| ctl_xoff | input | 1 | 1 requests one PAUSE frame; 0 has no effect |
| ctl_fdx | input | 1 | Full-duplex value written |
| evt_clr | input | 1 | Write-1 clear of the sticky event |
| rx_pause_vld | input | 1 | Received PAUSE frame strobe |
| rx_pause_quanta | input | QW | Pause duration in 512-bit-time units |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| frm_pending | input | 1 | A data frame is queued |
| frm_done | input | 1 | Current frame finished |
| frm_col | input | 1 | Current frame ended by early collision |
| crs | input | 1 | Carrier sense |
| col_in | input | 1 | Collision input |
| mac_addr_lo | input | SAW | Lower four station address bytes |
| grant_data | output | 1 | Start a data frame (pulse) |
| grant_pause | output | 1 | Start a PAUSE frame (pulse) |
| pause_sa_lo | output | SAW | PAUSE source address bytes 0 to 3 |
| stop_irq | output | 1 | Stop-complete interrupt pulse |
| stop_evt | output | 1 | Sticky copy of the interrupt |
| st_stop | output | 1 | Stop bit status |
| st_xoff | output | 1 | Pause request still pending |
| st_fdx | output | 1 | Full-duplex mode |
| st_rx_pause | output | 1 | Received-pause hold active |

## Verification
The assertions rely on well-formed frame-engine status. `frm_done` and `frm_col` pulse only while a granted frame is in flight, and never together. Two further assumptions cover the stop bit: once a stop interrupt has fired, the bit is not cleared in the very next clock while a pause request is pending, and `mac_en` changes only between register writes. The stimulus is driven from tasks that end each frame with one status pulse. It sweeps full-duplex mode against every combination of carrier and collision, and pause quanta from 0 through 6. It writes the stop and pause-request bits only at points where the bench already knows whether a frame is in flight.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_PAUSE = 2'd2
  } txarb_state_t;
endpackage

// File: rtl/txarb_ctrl_regs.sv
module txarb_ctrl_regs (
  input  logic clk,
  input  logic rst,
  input  logic mac_en,
  input  logic ctl_wr,
  input  logic ctl_stop,
  input  logic ctl_xoff,
  input  logic ctl_fdx,
  input  logic xoff_clr,
  input  logic irq,
  input  logic evt_clr,
  output logic stop_q,
  output logic xoff_q,
  output logic fdx_q,
  output logic evt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      xoff_q <= 1'b0;
      fdx_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (ctl_wr) stop_q <= ctl_stop;
      // set request wins over the self-clear of the previous one
      if (ctl_wr && ctl_xoff) xoff_q <= 1'b1;
      else if (xoff_clr)      xoff_q <= 1'b0;
      // duplex mode only moves while the MAC is disabled
      if (ctl_wr && !mac_en) fdx_q <= ctl_fdx;
      if (irq)          evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/txarb_pause_timer.sv
module txarb_pause_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [QW-1:0] quanta,
  input  logic          tick,
  output logic          active
);
  localparam logic [QW-1:0] ONE = QW'(1);

  logic [QW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= quanta;
      active <= (quanta != '0);
    end else if (active && tick) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) active <= 1'b0;
    end
  end
endmodule

// File: rtl/txarb_fsm.sv
module txarb_fsm
  import txarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_q,
  input  logic xoff_q,
  input  logic fdx_q,
  input  logic rx_hold,
  input  logic frm_pending,
  input  logic frm_done,
  input  logic frm_col,
  input  logic crs,
  input  logic col_in,
  output logic grant_data,
  output logic grant_pause,
  output logic irq,
  output logic xoff_clr
);
  txarb_state_t state;
  logic         stop_ack;
  logic         medium_ok;

  assign medium_ok = fdx_q | (~crs & ~col_in);
  // pause request bit drops on the same edge the PAUSE frame completes
  assign xoff_clr  = (state == ST_PAUSE) && frm_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      grant_data  <= 1'b0;
      grant_pause <= 1'b0;
      irq         <= 1'b0;
      stop_ack    <= 1'b0;
    end else begin
      grant_data  <= 1'b0;
      grant_pause <= 1'b0;
      irq         <= 1'b0;
      if (!stop_q) stop_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (xoff_q && medium_ok) begin
            grant_pause <= 1'b1;
            state       <= ST_PAUSE;
            if (!(stop_q && stop_ack) && !irq) irq <= 1'b1;
            if (stop_q) stop_ack <= 1'b1;
          end else if (stop_q) begin
            if (!stop_ack && !irq) begin
              irq      <= 1'b1;
              stop_ack <= 1'b1;
            end
          end else if (!rx_hold && frm_pending && medium_ok) begin
            grant_data <= 1'b1;
            state      <= ST_DATA;
          end
        end
        ST_DATA:  if (frm_done || frm_col) state <= ST_IDLE;
        ST_PAUSE: if (frm_done)            state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_tx_arbiter.sv
module eth_tx_arbiter #(
  parameter int QW  = 16,
  parameter int SAW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mac_en,
  input  logic           ctl_wr,
  input  logic           ctl_stop,
  input  logic           ctl_xoff,
  input  logic           ctl_fdx,
  input  logic           evt_clr,
  input  logic           rx_pause_vld,
  input  logic [QW-1:0]  rx_pause_quanta,
  input  logic           quanta_tick,
  input  logic           frm_pending,
  input  logic           frm_done,
  input  logic           frm_col,
  input  logic           crs,
  input  logic           col_in,
  input  logic [SAW-1:0] mac_addr_lo,
  output logic           grant_data,
  output logic           grant_pause,
  output logic [SAW-1:0] pause_sa_lo,
  output logic           stop_irq,
  output logic           stop_evt,
  output logic           st_stop,
  output logic           st_xoff,
  output logic           st_fdx,
  output logic           st_rx_pause
);
  logic xoff_clr;

  txarb_ctrl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .mac_en   (mac_en),
    .ctl_wr   (ctl_wr),
    .ctl_stop (ctl_stop),
    .ctl_xoff (ctl_xoff),
    .ctl_fdx  (ctl_fdx),
    .xoff_clr (xoff_clr),
    .irq      (stop_irq),
    .evt_clr  (evt_clr),
    .stop_q   (st_stop),
    .xoff_q   (st_xoff),
    .fdx_q    (st_fdx),
    .evt_q    (stop_evt)
  );

  txarb_pause_timer #(.QW(QW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (rx_pause_vld),
    .quanta (rx_pause_quanta),
    .tick   (quanta_tick),
    .active (st_rx_pause)
  );

  txarb_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_q      (st_stop),
    .xoff_q      (st_xoff),
    .fdx_q       (st_fdx),
    .rx_hold     (st_rx_pause),
    .frm_pending (frm_pending),
    .frm_done    (frm_done),
    .frm_col     (frm_col),
    .crs         (crs),
    .col_in      (col_in),
    .grant_data  (grant_data),
    .grant_pause (grant_pause),
    .irq         (stop_irq),
    .xoff_clr    (xoff_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) pause_sa_lo <= '0;
    else     pause_sa_lo <= mac_addr_lo;
  end
endmodule

// File: rtl/txarb_chk.sv
module txarb_chk #(
  parameter int SAW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           mac_en,
  input logic [SAW-1:0] mac_addr_lo,
  input logic           grant_data,
  input logic           grant_pause,
  input logic [SAW-1:0] pause_sa_lo,
  input logic           stop_irq,
  input logic           stop_evt,
  input logic           st_stop,
  input logic           st_fdx,
  input logic           st_rx_pause
);
  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grant_data && grant_pause)); // R2

  AST_STOP_BLOCKS_DATA: assert property (@(posedge clk) disable iff (rst)
    st_stop |=> !grant_data); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stop_irq |=> !stop_irq); // R4

  AST_RXP_BLOCKS_DATA: assert property (@(posedge clk) disable iff (rst)
    st_rx_pause |=> !grant_data); // R9

  AST_SA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> pause_sa_lo == $past(mac_addr_lo)); // R10

  AST_FDX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    mac_en |=> $stable(st_fdx)); // R12

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    stop_irq |=> stop_evt); // R13
endmodule

bind eth_tx_arbiter txarb_chk #(.SAW(SAW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mac_en      (mac_en),
  .mac_addr_lo (mac_addr_lo),
  .grant_data  (grant_data),
  .grant_pause (grant_pause),
  .pause_sa_lo (pause_sa_lo),
  .stop_irq    (stop_irq),
  .stop_evt    (stop_evt),
  .st_stop     (st_stop),
  .st_fdx      (st_fdx),
  .st_rx_pause (st_rx_pause)
);

// File: tb/sim_eth_tx_arbiter.sv
module sim_eth_tx_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int QW  = 16;
  localparam int SAW = 32;

  logic clk = 1'b0;
  logic rst, mac_en, ctl_wr, ctl_stop, ctl_xoff, ctl_fdx, evt_clr;
  logic rx_pause_vld, quanta_tick, frm_pending, frm_done, frm_col, crs, col_in;
  logic [QW-1:0]  rx_pause_quanta;
  logic [SAW-1:0] mac_addr_lo;
  logic grant_data, grant_pause, stop_irq, stop_evt, st_stop, st_xoff, st_fdx, st_rx_pause;
  logic [SAW-1:0] pause_sa_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_arbiter #(.QW(QW), .SAW(SAW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic x, input logic f);
    ctl_stop = s; ctl_xoff = x; ctl_fdx = f; ctl_wr = 1'b1;
    step(1);
    ctl_wr = 1'b0; ctl_xoff = 1'b0;
  endtask

  task automatic finish_frame;
    frm_done = 1'b1;
    step(1);
    frm_done = 1'b0;
  endtask

  task automatic rx_pause(input int q);
    rx_pause_quanta = QW'(q); rx_pause_vld = 1'b1;
    step(1);
    rx_pause_vld = 1'b0;
  endtask

  task automatic tick1;
    quanta_tick = 1'b1;
    step(1);
    quanta_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mac_en = 1'b0; ctl_wr = 1'b0; ctl_stop = 1'b0; ctl_xoff = 1'b0;
    ctl_fdx = 1'b0; evt_clr = 1'b0; rx_pause_vld = 1'b0; rx_pause_quanta = '0;
    quanta_tick = 1'b0; frm_pending = 1'b0; frm_done = 1'b0; frm_col = 1'b0;
    crs = 1'b0; col_in = 1'b0; mac_addr_lo = '0;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 outputs", {24'd0, grant_data, grant_pause, stop_irq, stop_evt,
          st_stop, st_xoff, st_fdx, st_rx_pause}, 32'd0);
    check("R1 sa", pause_sa_lo, 32'd0);

    // R2 basic grant and hold while in flight
    frm_pending = 1'b1;
    step(1);
    check("R2 grant", grant_data, 1);
    check("R2 no pause", grant_pause, 0);
    step(1);
    check("R2 single pulse", grant_data, 0);
    step(2);
    check("R2 held in flight", grant_data, 0);
    finish_frame();
    check("R2 idle edge", grant_data, 0);
    step(1);
    check("R2 regrant after done", grant_data, 1);
    frm_pending = 1'b0;
    finish_frame();

    // R11 sweep duplex x carrier x collision
    for (int f = 0; f < 2; f++) begin
      wr(1'b0, 1'b0, f[0]);
      check("R11 fdx set", st_fdx, f);
      for (int c = 0; c < 4; c++) begin
        logic exp;
        exp = f[0] | (c == 0);
        crs = c[0]; col_in = c[1]; frm_pending = 1'b1;
        step(1);
        check("R11 medium gate", grant_data, exp);
        frm_pending = 1'b0; crs = 1'b0; col_in = 1'b0;
        if (exp) finish_frame();
      end
    end
    wr(1'b0, 1'b0, 1'b0);

    // R12 duplex locked while enabled
    mac_en = 1'b1;
    wr(1'b0, 1'b0, 1'b1);
    check("R12 locked", st_fdx, 0);
    mac_en = 1'b0;
    wr(1'b0, 1'b0, 1'b1);
    check("R12 unlocked", st_fdx, 1);
    wr(1'b0, 1'b0, 1'b0);
    check("R12 back", st_fdx, 0);

    // R4 stop while idle
    wr(1'b1, 1'b0, 1'b0);
    check("R4 st_stop", st_stop, 1);
    check("R4 not yet", stop_irq, 0);
    step(1);
    check("R4 irq", stop_irq, 1);
    step(1);
    check("R4 pulse ends", stop_irq, 0);
    check("R13 evt set", stop_evt, 1);
    frm_pending = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      check("R4 no repeat", stop_irq, 0);
      check("R3 no grant stopped", grant_data, 0);
    end
    // R5 resume
    wr(1'b0, 1'b0, 1'b0);
    check("R5 edge", grant_data, 0);
    step(1);
    check("R5 resume grant", grant_data, 1);
    frm_pending = 1'b0;
    finish_frame();
    // R13 clear
    evt_clr = 1'b1;
    step(1);
    evt_clr = 1'b0;
    check("R13 evt cleared", stop_evt, 0);

    // R3 stop during a frame
    frm_pending = 1'b1;
    step(1);
    check("R3 grant", grant_data, 1);
    wr(1'b1, 1'b0, 1'b0);
    step(2);
    check("R3 no irq in flight", stop_irq, 0);
    finish_frame();
    check("R3 irq waits", stop_irq, 0);
    step(1);
    check("R3 irq after frame", stop_irq, 1);
    check("R3 no grant", grant_data, 0);
    step(2);
    check("R3 still held", grant_data, 0);
    wr(1'b0, 1'b0, 1'b0);
    step(1);
    check("R5 resume after frame stop", grant_data, 1);

    // R6 collision while stopping
    wr(1'b1, 1'b0, 1'b0);
    frm_col = 1'b1;
    step(1);
    frm_col = 1'b0;
    step(1);
    check("R6 irq after collision", stop_irq, 1);
    for (int i = 0; i < 3; i++) begin
      step(1);
      check("R6 hold", grant_data, 0);
    end
    wr(1'b0, 1'b0, 1'b0);
    step(1);
    check("R6 retry grant", grant_data, 1);
    frm_pending = 1'b0;
    finish_frame();

    // R7 pause request during a frame
    frm_pending = 1'b1;
    step(1);
    check("R7 data grant", grant_data, 1);
    wr(1'b0, 1'b1, 1'b0);
    check("R7 st_xoff", st_xoff, 1);
    finish_frame();
    check("R7 not yet", grant_pause, 0);
    step(1);
    check("R7 pause grant", grant_pause, 1);
    check("R7 irq", stop_irq, 1);
    check("R7 no data", grant_data, 0);
    step(2);
    check("R7 xoff held", st_xoff, 1);
    finish_frame();
    check("R7 xoff clears", st_xoff, 0);
    check("R7 no data yet", grant_data, 0);
    step(1);
    check("R7 data resumes", grant_data, 1);
    frm_pending = 1'b0;
    finish_frame();

    // R8 pause while stopped
    wr(1'b1, 1'b0, 1'b0);
    step(1);
    check("R8 stop irq", stop_irq, 1);
    step(1);
    wr(1'b1, 1'b1, 1'b0);
    step(1);
    check("R8 pause while stopped", grant_pause, 1);
    check("R8 no second irq", stop_irq, 0);
    finish_frame();
    step(2);
    check("R8 still stopped", st_stop, 1);
    check("R8 xoff done", st_xoff, 0);
    wr(1'b0, 1'b0, 1'b0);
    step(1);

    // R8 pause during received-pause hold
    rx_pause(50);
    check("R9 hold set", st_rx_pause, 1);
    wr(1'b0, 1'b1, 1'b0);
    step(1);
    check("R8 pause while rx hold", grant_pause, 1);
    finish_frame();
    check("R9 hold kept", st_rx_pause, 1);
    rx_pause(0);
    check("R9 zero clears", st_rx_pause, 0);

    // R9 sweep of pause quanta
    for (int q = 1; q <= 6; q++) begin
      rx_pause(q);
      check("R9 active", st_rx_pause, 1);
      frm_pending = 1'b1;
      for (int k = 1; k <= q; k++) begin
        tick1();
        check("R9 count", st_rx_pause, (k < q) ? 1 : 0);
        if (k < q) check("R9 blocked", grant_data, 0);
      end
      step(1);
      check("R9 grant after expiry", grant_data, 1);
      frm_pending = 1'b0;
      finish_frame();
    end
    // R9 reload
    rx_pause(3);
    tick1(); tick1();
    rx_pause(3);
    tick1(); tick1();
    check("R9 reloaded", st_rx_pause, 1);
    tick1();
    check("R9 reload expiry", st_rx_pause, 0);

    // R10 source address copy
    mac_addr_lo = 32'hC3D4_E5F6;
    step(1);
    check("R10 sa", pause_sa_lo, 32'hC3D4_E5F6);
    mac_addr_lo = 32'h0102_0304;
    step(1);
    check("R10 sa change", pause_sa_lo, 32'h0102_0304);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule